// File: doc/BRIEF.md
# PWM Comparison Unit with Buffered Update

This block watches the counter of a running PWM channel and emits a one-clock match pulse when that counter equals a programmed comparison value. Matching can be limited to one period out of every few channel periods. The comparison value and its configuration are double-buffered. Software writes new settings into shadow registers, and the block copies them into the active registers only at an update boundary. Update boundaries come from a separate update-period counter that advances on each channel period end.

A small sequencer guards the shadow registers. It has three states. `S_IDLE` means nothing is pending. `S_HELD` means a new value has been staged and the block is waiting for a mode write. `S_ARMED` means a complete set of shadow settings will be committed at the next boundary. The transitions are as follows:
- A value write moves any state to `S_HELD`.
- A mode write moves any state to `S_ARMED`.
- An update boundary in `S_ARMED` commits the shadow settings and returns to `S_IDLE`. If the same cycle carries a write, the write decides the next state.

An update boundary in `S_IDLE` or `S_HELD` changes nothing. Match events and commit events set sticky status flags. A mask with separate set and clear registers gates those flags onto an interrupt line.

Top module: `pwm_cmp_unit`

## Requirements
- R1: After reset the following are all zero: active and shadow settings, both period counters, status flags and interrupt mask. With the comparison disabled, `match_o` and `irq_o` stay low.
- R2: When `chan_cnt` equals the active value, the enable bit is set and the block is in the trigger period, `match_o` is high for exactly one clock, one cycle later. While `chan_cnt` holds that value, no further pulse follows.
- R3: With the active enable bit (mode bit 0) clear, `match_o` never rises.
- R4: The comparison period counter advances on each `period_end`. It wraps to zero after reaching the period field (mode bits [2P:P+1]). Matching is allowed only while it equals the trigger field (mode bits [P:1]).
- R5: The update counter advances on each `period_end`. A `period_end` that finds it at or above the update-period field (mode bits [3P:P*2+1]) is an update boundary, and the counter returns to zero.
- R6: A write to address 0 (value) only stages the value. The staged value reaches the active register only after a later write to address 1 (mode) and then a boundary. A value write after a mode write holds back the commit until another mode write arrives.
- R7: A new update-period field takes effect only once committed. The boundary that commits it is timed by the old one.
- R8: Status bit 0 is set by a match. Status bit 1 is set by each commit.
- R9: Writing ones to address 2 sets mask bits, and writing ones to address 3 clears them. A read of address 2 returns the mask. `irq_o` is the OR of status AND mask.
- R10: Reading address 4 returns the status and clears it. An event in the same cycle as that read remains set afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_cnt | input | CNT_W | Channel counter value |
| period_end | input | 1 | One-cycle strobe at the end of each channel period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address (0 value, 1 mode, 2 mask set, 3 mask clear, 4 status) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data (status at 4, mask at 2, zero elsewhere) |
| match_o | output | 1 | One-clock comparison match pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
Two things can coincide in one cycle. One is the read that clears the status register. The other is a new match or commit event that sets a flag in that same register. The bench drives the status read in the cycle where `chan_cnt` hits the active value, and also in the cycle of a `period_end` that commits armed settings. It expects the read data to show only the earlier flags, and a second read to show the flag raised by the coinciding event. A reference model tracks both counters and the sequencer, and a sweep over small period, trigger and update-period settings checks every probe against that model.

// File: rtl/pwm_cmp_pkg.sv
`timescale 1ns/1ps
package pwm_cmp_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_HELD  = 2'd1,
        S_ARMED = 2'd2
    } seq_state_t;

    localparam logic [2:0] ADDR_VAL  = 3'd0;
    localparam logic [2:0] ADDR_MODE = 3'd1;
    localparam logic [2:0] ADDR_IEN  = 3'd2;
    localparam logic [2:0] ADDR_IDIS = 3'd3;
    localparam logic [2:0] ADDR_STAT = 3'd4;

endpackage

// File: rtl/pwm_cmp_seq.sv
`timescale 1ns/1ps
module pwm_cmp_seq
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PER_W  = 4,
    parameter int DATA_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              boundary,
    output logic [CNT_W-1:0]  act_val,
    output logic              act_en,
    output logic [PER_W-1:0]  act_ctr,
    output logic [PER_W-1:0]  act_cpr,
    output logic [PER_W-1:0]  act_cupr,
    output logic              commit
);
    localparam int MODE_W = 1 + 3 * PER_W;

    seq_state_t          state_q, state_d;
    logic [CNT_W-1:0]    sh_val;
    logic [MODE_W-1:0]   sh_mode, act_mode;
    logic                wr_val, wr_mode;

    always_comb begin
        wr_val  = wr_en && (addr == ADDR_VAL);
        wr_mode = wr_en && (addr == ADDR_MODE);
        commit  = boundary && (state_q == S_ARMED);
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (wr_val)       state_d = S_HELD;
                else if (wr_mode) state_d = S_ARMED;
            end
            S_HELD: begin
                if (wr_mode)      state_d = S_ARMED;
            end
            S_ARMED: begin
                if (wr_val)       state_d = S_HELD;
                else if (wr_mode) state_d = S_ARMED;
                else if (commit)  state_d = S_IDLE;
            end
            default:              state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_val   <= '0;
            sh_mode  <= '0;
            act_val  <= '0;
            act_mode <= '0;
        end else begin
            if (commit) begin
                act_val  <= sh_val;
                act_mode <= sh_mode;
            end
            if (wr_val)  sh_val  <= wdata[CNT_W-1:0];
            if (wr_mode) sh_mode <= wdata[MODE_W-1:0];
        end
    end

    assign act_en   = act_mode[0];
    assign act_ctr  = act_mode[PER_W:1];
    assign act_cpr  = act_mode[2*PER_W:PER_W+1];
    assign act_cupr = act_mode[3*PER_W:2*PER_W+1];

    // R6: a staged value without a following mode write never reaches the active set
    p_held_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HELD) |=> ($stable(act_val) && $stable(act_mode)));

    // R6: with nothing pending the shadow value mirrors the active one
    p_idle_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (sh_val == act_val));

endmodule

// File: rtl/pwm_cmp_timebase.sv
`timescale 1ns/1ps
module pwm_cmp_timebase #(
    parameter int PER_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end,
    input  logic [PER_W-1:0] cpr,
    input  logic [PER_W-1:0] ctr,
    input  logic [PER_W-1:0] cupr,
    output logic             boundary,
    output logic             window
);
    logic [PER_W-1:0] upd_cnt, cpr_cnt;
    logic             upd_wrap, cpr_wrap;

    always_comb begin
        upd_wrap = (upd_cnt >= cupr);
        cpr_wrap = (cpr_cnt >= cpr);
        boundary = period_end && upd_wrap;
        window   = (cpr_cnt == ctr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_cnt <= '0;
            cpr_cnt <= '0;
        end else if (period_end) begin
            upd_cnt <= upd_wrap ? '0 : upd_cnt + 1'b1;
            cpr_cnt <= cpr_wrap ? '0 : cpr_cnt + 1'b1;
        end
    end

    // R5: a boundary returns the update counter to zero
    p_upd_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (upd_cnt == '0));

    // R4: both counters move only on a period end
    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> ($stable(cpr_cnt) && $stable(upd_cnt)));

endmodule

// File: rtl/pwm_cmp_irq.sv
`timescale 1ns/1ps
module pwm_cmp_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_status,
    input  logic       wr_ien,
    input  logic       wr_idis,
    input  logic [1:0] bits,
    input  logic       match_ev,
    input  logic       upd_ev,
    output logic [1:0] status,
    output logic [1:0] mask,
    output logic       irq
);
    logic [1:0] ev;

    assign ev  = {upd_ev, match_ev};
    assign irq = |(status & mask);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (rd_status ? 2'b00 : status) | ev;
            mask   <= (mask | (wr_ien ? bits : 2'b00)) & ~(wr_idis ? bits : 2'b00);
        end
    end

    // R10: an event is never lost, even beside a clearing read
    p_match_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match_ev |=> status[0]);
    p_update_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_ev |=> status[1]);

endmodule

// File: rtl/pwm_cmp_unit.sv
`timescale 1ns/1ps
module pwm_cmp_unit
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PER_W  = 4,
    parameter int DATA_W = (CNT_W > 1 + 3 * PER_W) ? CNT_W : 1 + 3 * PER_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  chan_cnt,
    input  logic              period_end,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              match_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] act_val;
    logic             act_en;
    logic [PER_W-1:0] act_ctr, act_cpr, act_cupr;
    logic             commit, boundary, window;
    logic             cond, cond_d, match_ev;
    logic [1:0]       status, mask;

    pwm_cmp_seq #(.CNT_W(CNT_W), .PER_W(PER_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .boundary(boundary), .act_val(act_val), .act_en(act_en),
        .act_ctr(act_ctr), .act_cpr(act_cpr), .act_cupr(act_cupr),
        .commit(commit)
    );

    pwm_cmp_timebase #(.PER_W(PER_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .period_end(period_end),
        .cpr(act_cpr), .ctr(act_ctr), .cupr(act_cupr),
        .boundary(boundary), .window(window)
    );

    pwm_cmp_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .rd_status(rd_en && (addr == ADDR_STAT)),
        .wr_ien(wr_en && (addr == ADDR_IEN)),
        .wr_idis(wr_en && (addr == ADDR_IDIS)),
        .bits(wdata[1:0]), .match_ev(match_ev), .upd_ev(commit),
        .status(status), .mask(mask), .irq(irq_o)
    );

    always_comb begin
        cond     = act_en && window && (chan_cnt == act_val);
        match_ev = cond && !cond_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_d  <= 1'b0;
            match_o <= 1'b0;
        end else begin
            cond_d  <= cond;
            match_o <= match_ev;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_STAT)     rdata[1:0] = status;
        else if (addr == ADDR_IEN) rdata[1:0] = mask;
    end

    // R2: a match lasts a single clock
    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    // R3: no match while the active enable bit is clear
    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |=> !match_o);

endmodule

// File: tb/tb_pwm_cmp_unit.sv
`timescale 1ns/1ps
module tb_pwm_cmp_unit;
    localparam int CW = 8;
    localparam int PW = 4;
    localparam int DW = (CW > 1 + 3 * PW) ? CW : 1 + 3 * PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          period_end = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [CW-1:0] chan_cnt = '1;
    logic [DW-1:0] rdata;
    logic          match_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int m_en = 0, m_ctr = 0, m_cpr = 0, m_cupr = 0, m_val = 0;
    int s_en = 0, s_ctr = 0, s_cpr = 0, s_cupr = 0, s_val = 0;
    int st = 0;            // 0 idle, 1 value held, 2 armed
    int upd_m = 0, cpr_m = 0;
    logic [1:0] m_stat = 2'b00;
    logic [1:0] m_mask = 2'b00;

    pwm_cmp_unit #(.CNT_W(CW), .PER_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .chan_cnt(chan_cnt), .period_end(period_end),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .match_o(match_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_tick();
        bit b, c;
        b = (upd_m >= m_cupr);
        c = (cpr_m >= m_cpr);
        upd_m = b ? 0 : upd_m + 1;
        cpr_m = c ? 0 : cpr_m + 1;
        if (b && st == 2) begin
            m_en = s_en; m_ctr = s_ctr; m_cpr = s_cpr; m_cupr = s_cupr; m_val = s_val;
            st = 0;
            m_stat[1] = 1'b1;
        end
    endfunction

    task automatic wr(input int a, input int d);
        addr = 3'(a); wdata = DW'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2) m_mask = m_mask | 2'(d);
        if (a == 3) m_mask = m_mask & ~2'(d);
    endtask

    task automatic wr_val(input int v);
        wr(0, v);
        s_val = v; st = 1;
    endtask

    task automatic wr_mode(input int en, input int ctr, input int cpr, input int cupr);
        wr(1, en | (ctr << 1) | (cpr << (1 + PW)) | (cupr << (1 + 2 * PW)));
        s_en = en; s_ctr = ctr; s_cpr = cpr; s_cupr = cupr; st = 2;
    endtask

    task automatic pend();
        period_end = 1'b1;
        @(negedge clk);
        period_end = 1'b0;
        model_tick();
        chk(irq_o == |(m_stat & m_mask), "R9 irq after period end", irq_o, |(m_stat & m_mask));
    endtask

    task automatic probe(input int v, input string req);
        bit exp;
        exp = (m_en != 0) && (v == m_val) && (cpr_m == m_ctr);
        chan_cnt = CW'(v);
        @(negedge clk);
        chan_cnt = '1;
        chk(match_o == exp, req, match_o, exp);
        if (exp) m_stat[0] = 1'b1;
        @(negedge clk);
        chk(match_o == 1'b0, "R2 pulse ends after one clock", match_o, 0);
    endtask

    task automatic rd_stat(input string req);
        chk(irq_o == |(m_stat & m_mask), "R9 irq line", irq_o, |(m_stat & m_mask));
        addr = 3'd4; rd_en = 1'b1;
        #1;
        chk(rdata[1:0] == m_stat, req, rdata[1:0], m_stat);
        @(negedge clk);
        rd_en = 1'b0;
        m_stat = 2'b00;
        chk(irq_o == 1'b0, "R10 irq low after clearing read", irq_o, 0);
    endtask

    task automatic rd_mask(input string req);
        addr = 3'd2; rd_en = 1'b1;
        #1;
        chk(rdata[1:0] == m_mask, req, rdata[1:0], m_mask);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_overlap(input bit hit, input bit tick);
        bit exp;
        exp = hit && (m_en != 0) && (cpr_m == m_ctr);
        addr = 3'd4; rd_en = 1'b1;
        if (hit) chan_cnt = CW'(m_val);
        period_end = tick;
        #1;
        chk(rdata[1:0] == m_stat, "R10 read shows only earlier flags", rdata[1:0], m_stat);
        @(negedge clk);
        rd_en = 1'b0; period_end = 1'b0; chan_cnt = '1;
        m_stat = 2'b00;
        if (exp) m_stat[0] = 1'b1;
        if (tick) model_tick();
        chk(match_o == exp, "R2 match beside status read", match_o, exp);
        rd_stat("R10 coinciding event kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(match_o == 1'b0, "R1 match after reset", match_o, 0);
        chk(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
        rd_mask("R1 mask after reset");
        probe(0, "R1 comparison disabled after reset");
        repeat (3) pend();
        rd_stat("R1 no flags without writes");

        // R9 mask set/clear
        wr(2, 3); rd_mask("R9 enable sets bits");
        wr(3, 1); rd_mask("R9 disable clears bits");
        wr(2, 1); rd_mask("R9 enable sets again");

        // R4 R5 R8 sweep of small configurations
        for (int cu = 0; cu < 3; cu++) begin
            for (int cp = 0; cp < 3; cp++) begin
                for (int ct = 0; ct <= cp; ct++) begin
                    wr_val(20 + cu * 9 + cp * 3 + ct);
                    wr_mode(1, ct, cp, cu);
                    for (int k = 0; k < 7; k++) begin
                        pend();
                        probe(m_val, "R4 match only in trigger period");
                    end
                    rd_stat("R8 match and update flags");
                end
            end
        end

        // R5 boundary spacing with update period 2
        wr_mode(1, 0, 0, 2);
        for (int k = 0; k < 4; k++) begin
            pend(); rd_stat("R5 boundary reached");
        end
        for (int k = 0; k < 6; k++) begin
            if (st == 0) wr_mode(1, 0, 0, 2);
            pend(); rd_stat("R5 update every third period");
        end

        // R7 new update period timed by the old one
        wr_mode(1, 0, 0, 0);
        for (int k = 0; k < 6; k++) begin
            pend(); rd_stat("R7 new period applied after commit");
            wr_mode(1, 0, 0, 0);
        end
        pend(); rd_stat("R7 commit each period");

        // R6 staged value stays out until mode write and boundary
        wr_val(40); wr_mode(1, 0, 0, 0); pend(); rd_stat("R6 setup commit");
        wr_val(77);
        for (int k = 0; k < 4; k++) begin
            pend();
            probe(77, "R6 unpaired value stays out");
            probe(40, "R6 old value still active");
        end
        rd_stat("R6 no update flag without mode write");
        wr_mode(1, 0, 0, 0);
        probe(77, "R6 no commit before boundary");
        pend();
        probe(77, "R6 committed after mode write and boundary");
        wr_mode(1, 0, 0, 0);
        wr_val(90);
        pend();
        probe(90, "R6 value write after arming holds commit");
        wr_mode(1, 0, 0, 0);
        pend();
        probe(90, "R6 commit after second mode write");
        rd_stat("R6 flags");

        // R2 value sweep and hold
        for (int v = 0; v < 255; v++) probe(v, "R2 value sweep");
        chan_cnt = CW'(m_val);
        @(negedge clk);
        chk(match_o == 1'b1, "R2 first cycle of hold", match_o, 1);
        m_stat[0] = 1'b1;
        @(negedge clk);
        chk(match_o == 1'b0, "R2 no repeat while held", match_o, 0);
        @(negedge clk);
        chk(match_o == 1'b0, "R2 no repeat while held", match_o, 0);
        chan_cnt = '1;
        @(negedge clk);
        rd_stat("R2 flags after hold");

        // R3 disabled comparison
        wr_mode(0, 0, 0, 0); pend();
        probe(m_val, "R3 disabled gives no match");
        wr_mode(1, 0, 0, 0); pend();
        probe(m_val, "R3 re-enabled matches");
        rd_stat("R3 flags");

        // R9 masked events keep irq low
        wr(3, 3); rd_mask("R9 all masked");
        probe(m_val, "R9 match while masked");
        chk(irq_o == 1'b0, "R9 irq masked", irq_o, 0);
        wr(2, 3);
        chk(irq_o == 1'b1, "R9 irq after unmask", irq_o, 1);
        rd_stat("R9 flags");

        // R10 read coinciding with events
        rd_overlap(1'b1, 1'b0);
        wr_mode(1, 0, 0, 0);
        rd_overlap(1'b0, 1'b1);
        wr_mode(1, 0, 0, 0);
        rd_overlap(1'b1, 1'b1);

        summary();
    end
endmodule